// File: doc/BRIEF.md
# Parity-Lane Write Mask Merger

This block sits in the write path of a memory whose 36-bit word is split into four 9-bit byte lanes. Each lane has eight data bits and a parity bit as its top bit. A row cycle starts with a one-cycle strobe-edge pulse. On that pulse the block stores a 4-bit parity mask from the parity pins, one bit per lane. From then on, every write builds a merged word from three inputs: the word already stored, the new write data and the byte-lane selects.

In a selected lane the eight data bits are always replaced as a whole, because data bits have no per-bit control. The parity bit of a selected lane is replaced only when its stored mask bit is one. When the mask bit is zero, the parity bit keeps its stored value. An unselected lane is left untouched, whatever the mask holds.

The stored mask stays the same for every write of a page-mode burst until the next strobe-edge pulse. The merge is purely combinational, so the merged word is valid in the same cycle as its inputs. The array that stores the words is outside this block.

Top module: `parity_wmask_merge`

## Requirements
- R1: Lane n occupies word bits 9n through 9n+8. Bits 9n..9n+7 are its data bits and bit 9n+8 (bits 8, 17, 26, 35) is its parity bit. Bit n of `mask_in`, of the stored mask and of `lane_sel` all refer to lane n.
- R2: On a rising clock edge with `row_fall` high, the stored mask takes the value of `mask_in`. On every other edge, `mask_in` has no effect.
- R3: When lane n is selected and stored mask bit n is 1, `merged_word` bit 9n+8 equals `wr_data` bit 9n+8.
- R4: When lane n is selected and stored mask bit n is 0, `merged_word` bit 9n+8 equals `old_word` bit 9n+8.
- R5: When lane n is selected, `merged_word` bits 9n..9n+7 equal the same bits of `wr_data`, whatever the mask holds.
- R6: When lane n is not selected, all nine bits of the lane in `merged_word` equal `old_word`, whatever the mask holds.
- R7: One stored mask applies to every write after it, over any number of cycles, until the next edge with `row_fall` high.
- R8: While `rst_n` is low, the stored mask is cleared to all zeros, so selected parity bits keep their old values until a mask is loaded.
- R9: `merged_word` follows changes on `wr_data`, `old_word` and `lane_sel` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the stored mask |
| row_fall | input | 1 | One-cycle pulse marking the row-strobe edge; loads the mask |
| mask_in | input | 4 | Parity mask from the parity pins, one bit per lane |
| lane_sel | input | 4 | Byte-lane write selects, one bit per lane |
| wr_data | input | 36 | New write data |
| old_word | input | 36 | Word currently stored at the addressed location |
| merged_word | output | 36 | Word to be written back |

## Verification
The assertions check the following on every cycle, lane by lane:
- the stored mask loads on a strobe pulse and holds otherwise;
- an unselected lane passes through unchanged;
- the data bits of a selected lane come from the write data;
- the parity bit of a selected lane follows the stored mask bit.

Other behaviours only the bench's scenarios can show:
- that noise on the mask pins between strobe pulses never reaches a long burst;
- the cleared mask right after reset;
- the same-cycle response of the merge to input changes.

The bench sweeps all sixteen masks, against all sixteen lane-select patterns and several data patterns.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

   localparam int unsigned PMW_LANES_DEF     = 4;
   localparam int unsigned PMW_LANE_BITS_DEF = 9;

   // lowest word bit of a lane; the parity bit is lane_lsb + lane_bits - 1
   function automatic int unsigned lane_lsb(input int unsigned lane,
                                            input int unsigned lane_bits);
      return lane * lane_bits;
   endfunction

endpackage

// File: rtl/pmw_mask_latch.sv
module pmw_mask_latch #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("pmw_mask_latch: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/pmw_lane_merge.sv
module pmw_lane_merge #(
   parameter int unsigned LANE_BITS = 9
) (
   input  logic                 sel,
   input  logic                 par_en,
   input  logic [LANE_BITS-1:0] wr,
   input  logic [LANE_BITS-1:0] old,
   output logic [LANE_BITS-1:0] q
);

   localparam int unsigned DATA_BITS = LANE_BITS - 1;

   if (LANE_BITS < 2) begin : g_bad_lane
      $error("pmw_lane_merge: a lane needs data bits plus a parity bit");
   end

   // data bits: whole-lane control only
   assign q[DATA_BITS-1:0] = sel ? wr[DATA_BITS-1:0] : old[DATA_BITS-1:0];

   // parity bit: lane select and the stored mask bit must both allow it
   assign q[DATA_BITS] = (sel && par_en) ? wr[DATA_BITS] : old[DATA_BITS];

endmodule

// File: rtl/parity_wmask_merge.sv
module parity_wmask_merge
   import pmw_pkg::*;
#(
   parameter int unsigned LANES     = PMW_LANES_DEF,
   parameter int unsigned LANE_BITS = PMW_LANE_BITS_DEF
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       row_fall,
   input  logic [LANES-1:0]           mask_in,
   input  logic [LANES-1:0]           lane_sel,
   input  logic [LANES*LANE_BITS-1:0] wr_data,
   input  logic [LANES*LANE_BITS-1:0] old_word,
   output logic [LANES*LANE_BITS-1:0] merged_word
);

   localparam int unsigned WORD_BITS = LANES * LANE_BITS;

   if (LANES < 1) begin : g_bad_lanes
      $error("parity_wmask_merge: LANES must be at least 1");
   end
   if (WORD_BITS > 1024) begin : g_bad_word
      $error("parity_wmask_merge: word wider than supported");
   end

   logic [LANES-1:0] mask_q;

   pmw_mask_latch #(
      .W (LANES)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (row_fall),
      .d     (mask_in),
      .q     (mask_q)
   );

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      localparam int unsigned LSB = lane_lsb(n, LANE_BITS);
      pmw_lane_merge #(
         .LANE_BITS (LANE_BITS)
      ) u_merge (
         .sel    (lane_sel[n]),
         .par_en (mask_q[n]),
         .wr     (wr_data[LSB +: LANE_BITS]),
         .old    (old_word[LSB +: LANE_BITS]),
         .q      (merged_word[LSB +: LANE_BITS])
      );
   end

endmodule

// File: rtl/parity_wmask_merge_chk.sv
module parity_wmask_merge_chk #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_BITS = 9
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       row_fall,
   input logic [LANES-1:0]           mask_in,
   input logic [LANES-1:0]           lane_sel,
   input logic [LANES*LANE_BITS-1:0] wr_data,
   input logic [LANES*LANE_BITS-1:0] old_word,
   input logic [LANES*LANE_BITS-1:0] merged_word,
   input logic [LANES-1:0]           mask_q
);

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      row_fall |=> (mask_q == $past(mask_in)));                      // R2

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !row_fall |=> $stable(mask_q));                                 // R7

   for (genvar n = 0; n < LANES; n++) begin : g_lane_chk
      localparam int unsigned LSB = n * LANE_BITS;
      localparam int unsigned PB  = LSB + LANE_BITS - 1;

      AST_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         !lane_sel[n] |-> (merged_word[LSB +: LANE_BITS] == old_word[LSB +: LANE_BITS])); // R6

      AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         lane_sel[n] |-> (merged_word[LSB +: LANE_BITS-1] == wr_data[LSB +: LANE_BITS-1])); // R5

      AST_PAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_sel[n] && mask_q[n]) |-> (merged_word[PB] == wr_data[PB]));  // R3

      AST_PAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_sel[n] && !mask_q[n]) |-> (merged_word[PB] == old_word[PB])); // R4
   end

endmodule

bind parity_wmask_merge parity_wmask_merge_chk #(
   .LANES     (LANES),
   .LANE_BITS (LANE_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .row_fall    (row_fall),
   .mask_in     (mask_in),
   .lane_sel    (lane_sel),
   .wr_data     (wr_data),
   .old_word    (old_word),
   .merged_word (merged_word),
   .mask_q      (mask_q)
);

// File: tb/parity_wmask_merge_bench.sv
`timescale 1ns/1ps
module parity_wmask_merge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        row_fall = 1'b0;
   logic [3:0]  mask_in = '0;
   logic [3:0]  lane_sel = '0;
   logic [35:0] wr_data = '0;
   logic [35:0] old_word = '0;
   logic [35:0] merged_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   parity_wmask_merge u_parity_wmask_merge (
      .clk         (clk),
      .rst_n       (rst_n),
      .row_fall    (row_fall),
      .mask_in     (mask_in),
      .lane_sel    (lane_sel),
      .wr_data     (wr_data),
      .old_word    (old_word),
      .merged_word (merged_word)
   );

   // R1 layout: lane n = bits 9n..9n+8, parity at 9n+8
   task automatic check_lanes(input logic [3:0] m, input string ctx);
      for (int n = 0; n < 4; n++) begin
         logic [7:0] exp_d;
         logic       exp_p;
         string      tag_d;
         string      tag_p;
         if (lane_sel[n]) begin
            exp_d = wr_data[9*n +: 8];
            exp_p = m[n] ? wr_data[9*n+8] : old_word[9*n+8];
            tag_d = "R5";
            tag_p = m[n] ? "R3" : "R4";
         end else begin
            exp_d = old_word[9*n +: 8];
            exp_p = old_word[9*n+8];
            tag_d = "R6";
            tag_p = "R6";
         end
         checks++;
         if (merged_word[9*n +: 8] !== exp_d) begin
            fails++;
            $display("FAIL %s/R1 %s lane %0d data: got %h expected %h",
                     tag_d, ctx, n, merged_word[9*n +: 8], exp_d);
         end
         checks++;
         if (merged_word[9*n+8] !== exp_p) begin
            fails++;
            $display("FAIL %s/R1 %s lane %0d parity: got %b expected %b",
                     tag_p, ctx, n, merged_word[9*n+8], exp_p);
         end
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired: got hung run expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [35:0] olds [3];
      logic [35:0] wrs  [3];
      olds[0] = 36'h000000000; wrs[0] = 36'hFFFFFFFFF;
      olds[1] = 36'hFFFFFFFFF; wrs[1] = 36'h000000000;
      olds[2] = 36'h123456789; wrs[2] = 36'hEDCBA9876;

      // R8: mask cleared by reset, so parity bits keep old values
      mask_in = 4'hF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      lane_sel = 4'hF; old_word = 36'h000000000; wr_data = 36'hFFFFFFFFF;
      #1;
      checks++;
      if (merged_word !== 36'h7FBFDFEFF) begin
         fails++;
         $display("FAIL R8 after reset: got %h expected %h", merged_word, 36'h7FBFDFEFF);
      end
      check_lanes(4'h0, "R8 reset mask");

      // R2/R7: load each mask once, then a long burst with noise on mask_in
      for (int m = 0; m < 16; m++) begin
         @(negedge clk);
         row_fall = 1'b1;
         mask_in  = m[3:0];
         @(negedge clk);
         row_fall = 1'b0;
         for (int s = 0; s < 16; s++) begin
            for (int p = 0; p < 3; p++) begin
               mask_in  = ~m[3:0] ^ s[3:0];   // R2: ignored without row_fall
               lane_sel = s[3:0];
               old_word = olds[p];
               wr_data  = wrs[p];
               #1;
               check_lanes(m[3:0], "R7 burst");
               @(negedge clk);
            end
         end
      end

      // R9: same-cycle response, no clock edge between change and sample
      @(negedge clk);
      row_fall = 1'b1; mask_in = 4'b0101;
      @(negedge clk);
      row_fall = 1'b0;
      lane_sel = 4'b0011; old_word = 36'h0F0F0F0F0; wr_data = 36'hA5A5A5A5A;
      #0.5;
      check_lanes(4'b0101, "R9 first");
      lane_sel = 4'b1110; wr_data = 36'h5A5A5A5A5;
      #0.5;
      check_lanes(4'b0101, "R9 second");
      old_word = 36'hFFFFFFFFF;
      #0.5;
      check_lanes(4'b0101, "R9 third");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule